// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is an SPI target that holds the configuration bytes of a small TFT panel controller. A host frames each transaction with an active-low chip select. It sends an address byte whose top bit picks a read or a write. On a write, it follows that byte with one data byte. On a read, it clocks the addressed register out in the next byte slot. The stored registers are presented in parallel to the rest of the controller as one flat vector.

Register 0 is a fixed identification byte. One register acts as a soft-reset control: writing it with bit 0 cleared returns every register to its power-up default and emits a one-cycle strobe to internal logic. SCLK, MOSI and chip select are brought into the system clock domain through two-flop synchronisers. The system clock must therefore run at least eight times faster than SCLK.

Top module: `spi_cfg_regbank`

## Requirements
- R1: After `rst_n` is released, register 0x01 holds 0x0F, 0x02 holds 0x2E, 0x03 holds 0x12, 0x04 holds 0x01 and 0x06 holds 0x03 (both direction bits, bits 1:0, set). Every other writable register holds 0x00. Register n appears on `cfg_regs[8n+7:8n]`.
- R2: The bus uses SPI mode 0. MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge. Every byte is sent most significant bit first. In the first byte, bit 7 = 1 selects a read, bit 7 = 0 selects a write, and bits 6:0 give the register address.
- R3: A write frame stores its second byte in the addressed register. The new value appears on `cfg_regs` within a few system clocks of the eighth data bit's rising edge, and before chip select rises.
- R4: In a read frame, the addressed register's byte is driven on MISO during the second byte slot, MSB first. Bit 7 is valid before the first rising edge of that slot.
- R5: Register 0x00 always reads 0x96, always shows 0x96 on `cfg_regs[7:0]`, and ignores writes.
- R6: Writes to addresses above 0x44 change no register, and reads of those addresses return 0x00. Address 0x44 itself is a normal register.
- R7: Writing register 0x04 with bit 0 = 0 restores all registers to their R1 defaults and raises `soft_rst_pulse` for exactly one system clock. Writing 0x04 with bit 0 = 1 only stores the byte.
- R8: If chip select rises before the eighth data bit, the frame is discarded and no register changes. This also applies when chip select rises inside the address byte.
- R9: Bytes after the second byte of a frame are ignored.
- R10: Registers change only as a direct result of a committed write. Nothing changes while chip select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial read data to host, low when not selected |
| cfg_regs | output | (LAST_ADDR+1)*8 | All registers side by side, register n in bits 8n+7:8n |
| soft_rst_pulse | output | 1 | One-cycle strobe on a soft reset write |

## Verification
A bit counter that is off by one shows up directly on the ports: a written value lands rotated or in the wrong register, on `cfg_regs` one system clock after the commit. A transmit shifter that moves on the wrong falling edge shows a shifted byte on MISO within the same read slot. Stale frame state after an aborted transfer appears as a corrupted register in the very next frame. A soft reset that misses a register leaves a non-default byte on `cfg_regs` one clock after the strobe.

// File: rtl/spi_cfg_regbank.sv
`timescale 1ns/1ps
module spi_cfg_regbank #(
  parameter int         LAST_ADDR = 'h44,
  parameter int         SRST_ADDR = 'h04,
  parameter logic [7:0] CHIP_ID   = 8'h96
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_cs_n,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  output logic [(LAST_ADDR+1)*8-1:0] cfg_regs,
  output logic                       soft_rst_pulse
);
  localparam int         NREG   = LAST_ADDR + 1;
  localparam logic [6:0] LAST_A = 7'(LAST_ADDR);
  localparam logic [6:0] SRST_A = 7'(SRST_ADDR);

  function automatic logic [7:0] dflt(input int a);
    case (a)
      1:       return 8'h0F;
      2:       return 8'h2E;
      3:       return 8'h12;
      6:       return 8'h03;
      default: return (a == SRST_ADDR) ? 8'h01 : 8'h00;
    endcase
  endfunction

  logic [2:0] sclk_s;
  logic [1:0] cs_s, mosi_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end

  wire sclk_rise = sclk_s[1] & ~sclk_s[2];
  wire sclk_fall = ~sclk_s[1] & sclk_s[2];
  wire cs_act    = ~cs_s[1];

  logic [2:0] bit_cnt;
  logic [1:0] byte_idx;
  logic [6:0] rx_sh, addr_q;
  logic       rd_q;
  logic [7:0] tx_sh, rd_val;
  logic [7:0] mem [1:LAST_ADDR];

  wire [7:0] rx_byte = {rx_sh, mosi_s[1]};
  wire [6:0] rd_addr = rx_byte[6:0];
  wire byte_done = cs_act & sclk_rise & (bit_cnt == 3'd7);

  always_comb begin
    if (rd_addr == 7'd0)         rd_val = CHIP_ID;
    else if (rd_addr <= LAST_A)  rd_val = mem[rd_addr];
    else                         rd_val = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      rx_sh    <= '0;
      addr_q   <= '0;
      rd_q     <= 1'b0;
      tx_sh    <= '0;
    end else if (!cs_act) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      tx_sh    <= '0;
    end else if (sclk_rise) begin
      rx_sh   <= rx_byte[6:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) begin
        if (byte_idx == 2'd0) begin
          rd_q   <= rx_byte[7];
          addr_q <= rd_addr;
          if (rx_byte[7]) tx_sh <= rd_val;
        end
        if (byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
      end
    end else if (sclk_fall && byte_idx == 2'd1 && bit_cnt != 3'd0 && rd_q) begin
      tx_sh <= {tx_sh[6:0], 1'b0};
    end

  assign spi_miso = cs_act & tx_sh[7];

  wire wr_hit   = byte_done & (byte_idx == 2'd1) & ~rd_q &
                  (addr_q != 7'd0) & (addr_q <= LAST_A);
  wire srst_hit = wr_hit & (addr_q == SRST_A) & ~rx_byte[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      soft_rst_pulse <= 1'b0;
      for (int i = 1; i < NREG; i++) mem[i] <= dflt(i);
    end else begin
      soft_rst_pulse <= srst_hit;
      if (srst_hit)
        for (int i = 1; i < NREG; i++) mem[i] <= dflt(i);
      else if (wr_hit)
        mem[addr_q] <= rx_byte;
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    if (g == 0) begin : g_id
      assign cfg_regs[7:0] = CHIP_ID;
    end else begin : g_reg
      assign cfg_regs[g*8 +: 8] = mem[g];
    end
  end
endmodule

module spi_cfg_regbank_chk #(
  parameter int LAST_ADDR = 'h44
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sclk_rise,
  input logic                       cs_act,
  input logic [1:0]                 byte_idx,
  input logic                       soft_rst_pulse,
  input logic [(LAST_ADDR+1)*8-1:0] cfg_regs
);
  assert_change_after_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_regs) |-> $past(sclk_rise));

  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_regs) |-> $past(cs_act));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !soft_rst_pulse);

  assert_pulse_from_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> $past(sclk_rise && cs_act));

  assert_pulse_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (cfg_regs[15:8] == 8'h0F && cfg_regs[23:16] == 8'h2E &&
                        cfg_regs[31:24] == 8'h12));

  assert_byte_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_idx != 2'd3);
endmodule

bind spi_cfg_regbank spi_cfg_regbank_chk #(.LAST_ADDR(LAST_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_act(cs_act),
  .byte_idx(byte_idx), .soft_rst_pulse(soft_rst_pulse), .cfg_regs(cfg_regs)
);

// File: tb/sim_spi_cfg_regbank.sv
`timescale 1ns/1ps
module sim_spi_cfg_regbank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, soft_rst_pulse;
  logic [69*8-1:0] cfg_regs;
  int checks = 0, failures = 0, pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_cfg_regbank u0 (.clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .cfg_regs(cfg_regs), .soft_rst_pulse(soft_rst_pulse));

  always @(negedge clk) if (soft_rst_pulse) pulses++;

  function automatic logic [7:0] reg_at(input int n);
    return cfg_regs[n*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = tx[i];
      wait_clk(8);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      wait_clk(8);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_on;  spi_cs_n = 1'b0; wait_clk(8);  endtask
  task automatic cs_off; wait_clk(4); spi_cs_n = 1'b1; wait_clk(12); endtask

  task automatic spi_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_on();
    spi_bits({1'b0, a}, 8, r);
    spi_bits(d, 8, r);
    cs_off();
  endtask

  task automatic spi_read(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] r;
    cs_on();
    spi_bits({1'b1, a}, 8, r);
    spi_bits(8'h00, 8, d);
    cs_off();
  endtask

  task automatic t_reset;
    chk("R1 reg01", reg_at(1), 8'h0F);
    chk("R1 reg02", reg_at(2), 8'h2E);
    chk("R1 reg03", reg_at(3), 8'h12);
    chk("R1 reg04", reg_at(4), 8'h01);
    chk("R1 reg06", reg_at(6), 8'h03);
    chk("R1 reg07", reg_at(7), 8'h00);
    chk("R5 id slot", reg_at(0), 8'h96);
    chk("R1 miso idle", {7'd0, spi_miso}, 8'h00);
  endtask

  task automatic t_write_read;
    logic [7:0] d;
    spi_write(7'h07, 8'h5A);
    chk("R3 reg07", reg_at(7), 8'h5A);
    spi_read(7'h07, d);
    chk("R4 read07", d, 8'h5A);
    spi_write(7'h01, 8'h80);
    chk("R2 msb first", reg_at(1), 8'h80);
    spi_write(7'h10, 8'hA7);
    spi_read(7'h10, d);
    chk("R4 read10", d, 8'hA7);
    spi_write(7'h44, 8'h3C);
    chk("R6 last addr", reg_at(68), 8'h3C);
    spi_read(7'h44, d);
    chk("R4 read44", d, 8'h3C);
    spi_read(7'h02, d);
    chk("R2 read default", d, 8'h2E);
  endtask

  task automatic t_id;
    logic [7:0] d;
    spi_write(7'h00, 8'h11);
    spi_read(7'h00, d);
    chk("R5 id read", d, 8'h96);
    chk("R5 id slot after write", reg_at(0), 8'h96);
  endtask

  task automatic t_out_of_range;
    logic [7:0] d;
    spi_write(7'h45, 8'hFF);
    chk("R6 alias reg05", reg_at(5), 8'h00);
    chk("R6 reg44 kept", reg_at(68), 8'h3C);
    spi_read(7'h45, d);
    chk("R6 read45", d, 8'h00);
    spi_read(7'h7F, d);
    chk("R6 read7F", d, 8'h00);
  endtask

  task automatic t_abort;
    logic [7:0] r;
    cs_on();
    spi_bits(8'h02, 8, r);
    spi_bits(8'h55, 5, r);
    cs_off();
    chk("R8 abort data", reg_at(2), 8'h2E);
    cs_on();
    spi_bits(8'h03, 4, r);
    cs_off();
    spi_write(7'h03, 8'h21);
    chk("R8 next frame clean", reg_at(3), 8'h21);
  endtask

  task automatic t_extra;
    logic [7:0] r;
    cs_on();
    spi_bits(8'h03, 8, r);
    spi_bits(8'h07, 8, r);
    spi_bits(8'h15, 8, r);
    cs_off();
    chk("R9 reg03", reg_at(3), 8'h07);
    chk("R9 reg15 untouched", reg_at(21), 8'h00);
    chk("R9 reg07 untouched", reg_at(7), 8'h5A);
  endtask

  task automatic t_soft_reset;
    chk("R7 no early pulse", 8'(pulses), 8'd0);
    spi_write(7'h04, 8'h03);
    chk("R7 store bit0 set", reg_at(4), 8'h03);
    chk("R7 no pulse bit0 set", 8'(pulses), 8'd0);
    spi_write(7'h04, 8'h02);
    chk("R7 one pulse", 8'(pulses), 8'd1);
    chk("R7 reg01 default", reg_at(1), 8'h0F);
    chk("R7 reg03 default", reg_at(3), 8'h12);
    chk("R7 reg04 default", reg_at(4), 8'h01);
    chk("R7 reg06 default", reg_at(6), 8'h03);
    chk("R7 reg07 default", reg_at(7), 8'h00);
    chk("R7 reg10 default", reg_at(16), 8'h00);
    chk("R7 reg44 default", reg_at(68), 8'h00);
    chk("R10 id kept", reg_at(0), 8'h96);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_read();
    t_id();
    t_out_of_range();
    t_abort();
    t_extra();
    t_soft_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule